// File: doc/BRIEF.md
# Bidirectional Mailbox Bypass

This block holds two single-word mailboxes that sit next to a FIFO datapath. Two ports use them to pass a word to each other without touching the FIFO storage. One mailbox carries a word from port A to port B. The other carries a word from port B to port A. Each port runs on its own clock, and the two clocks may be unrelated.

A port reaches a mailbox when its chip select, its enable and its mailbox-select input are all high at a rising edge of its clock. The write/read line then picks the operation. A write lands in the outgoing mailbox. A read returns the contents of the incoming mailbox. Each mailbox has a ready flag on the receiving side. The flag rises when a word has been stored and falls when the receiver reads it.

The set and clear events cross between the clock domains as toggles through synchroniser chains. The writer therefore treats a mailbox as occupied until the clear has come back to its own domain. The stored width follows the bus-size setting: 36, 18 or 9 bits, held in the low bits, with the unused high bits reading as zero.

Top module: `mailbox_bypass`

## Requirements
- R1: A port-A write (a_cs, a_en, a_mb_sel and a_wr high at a clk_a rising edge) stores a_wdata in the A-to-B mailbox. A later port-B read (b_cs, b_en, b_mb_sel high, b_wr low) puts that word on b_rdata at the clk_b edge of the read.
- R2: A port-B write stores b_wdata in the B-to-A mailbox. A later port-A read puts that word on a_rdata at the clk_a edge of the read.
- R3: bus_size sets the stored width: 2'b00 keeps bits [35:0], 2'b01 keeps bits [17:0], and 2'b10 or 2'b11 keep bits [8:0]. All bits above the kept width read as zero.
- R4: After a write is accepted, the receiver's ready flag (b_mail_ready for A-to-B, a_mail_ready for B-to-A) is high by the third rising edge of the receiver's clock.
- R5: A write to a mailbox is ignored, and the stored word is kept, while the mailbox is occupied. A mailbox is occupied from the accepting write until 3 writer-clock edges after the receiver has read it.
- R6: A receiver read of a mailbox whose flag is set clears the flag at that same edge. A read while the flag is clear leaves the flag low.
- R7: While rst_n is low, both ready flags and both read-data outputs are zero.
- R8: No mailbox access takes place at an edge where the port's chip select, enable or mailbox-select input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Full reset, active low, asynchronous assert |
| bus_size | input | 2 | Port-B width select: 00=36, 01=18, 1x=9 bits |
| a_cs | input | 1 | Port A chip select, active high |
| a_en | input | 1 | Port A enable, active high |
| a_mb_sel | input | 1 | Port A mailbox select (high = mailbox access) |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Port A read data (B-to-A mailbox) |
| a_mail_ready | output | 1 | New word waiting for port A |
| b_cs | input | 1 | Port B chip select, active high |
| b_en | input | 1 | Port B enable, active high |
| b_mb_sel | input | 1 | Port B mailbox select (high = mailbox access) |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_wdata | input | 36 | Port B write data |
| b_rdata | output | 36 | Port B read data (A-to-B mailbox) |
| b_mail_ready | output | 1 | New word waiting for port B |

## Verification
Two functions can meet in one moment: a receiver read that empties a mailbox, and a new write to that same mailbox from the other side. The bench provokes this by driving a port-B read and a port-A write of a new word together. Each lands at the next edge of its own port clock, while the clear is still crossing back to the writer. The result is judged at the ports. The read must return the old word and drop b_mail_ready. The flag must then stay low for several port-B cycles, which shows that the colliding write was dropped.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_W = 36;

  typedef enum logic [1:0] {
    SZ_LONG  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_BYTE  = 2'b10,
    SZ_BYTE2 = 2'b11
  } bus_size_e;

  // Kept bits for each bus-size setting.
  function automatic logic [MB_W-1:0] lane_mask(input bus_size_e sz);
    logic [MB_W-1:0] m;
    case (sz)
      SZ_LONG: m = '1;
      SZ_HALF: m = {{(MB_W-18){1'b0}}, {18{1'b1}}};
      default: m = {{(MB_W-9){1'b0}}, {9{1'b1}}};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            wclk,
  input  logic            rclk,
  input  logic            rst_n,
  input  bus_size_e       size,
  input  logic            wr_req,
  input  logic [MB_W-1:0] wr_data,
  input  logic            rd_req,
  output logic [MB_W-1:0] rd_data,
  output logic            full_w,
  output logic            ready_r,
  output logic            wr_accept,
  output logic            rd_take
);
  logic            set_tgl, clr_tgl;
  logic            set_seen_r, clr_seen_w;
  logic [MB_W-1:0] mail_q;

  // Writer domain: data capture and set toggle.
  assign full_w    = set_tgl ^ clr_seen_w;
  assign wr_accept = wr_req & ~full_w;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      set_tgl <= 1'b0;
      mail_q  <= '0;
    end else if (wr_accept) begin
      set_tgl <= ~set_tgl;
      mail_q  <= wr_data & lane_mask(size);
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk(rclk), .rst_n(rst_n), .d(set_tgl), .q(set_seen_r));

  // Reader domain: flag, read register and clear toggle.
  assign ready_r = set_seen_r ^ clr_tgl;
  assign rd_take = rd_req & ready_r;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      clr_tgl <= 1'b0;
      rd_data <= '0;
    end else begin
      if (rd_take) clr_tgl <= ~clr_tgl;
      if (rd_req)  rd_data <= mail_q & lane_mask(size);
    end
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(wclk), .rst_n(rst_n), .d(clr_tgl), .q(clr_seen_w));

  // Occupied mailbox keeps its word.
  assert_no_overwrite_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    full_w |=> $stable(mail_q));

  // An accepted write leaves the mailbox occupied.
  assert_write_occupies_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_accept |=> full_w);

  // Reading a set flag takes it down.
  assert_read_clears_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_take |=> !ready_r);

  // Stored word has nothing above the selected width.
  assert_width_mask_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_accept |=> ((mail_q & ~lane_mask($past(size))) == '0));
endmodule

// File: rtl/mailbox_bypass.sv
module mailbox_bypass
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_a,
  input  logic            clk_b,
  input  logic            rst_n,
  input  logic [1:0]      bus_size,
  input  logic            a_cs,
  input  logic            a_en,
  input  logic            a_mb_sel,
  input  logic            a_wr,
  input  logic [MB_W-1:0] a_wdata,
  output logic [MB_W-1:0] a_rdata,
  output logic            a_mail_ready,
  input  logic            b_cs,
  input  logic            b_en,
  input  logic            b_mb_sel,
  input  logic            b_wr,
  input  logic [MB_W-1:0] b_wdata,
  output logic [MB_W-1:0] b_rdata,
  output logic            b_mail_ready
);
  localparam int NCH = 2;  // index 0: A to B, index 1: B to A

  bus_size_e size_e;
  assign size_e = bus_size_e'(bus_size);

  // Per-port mailbox strobes, brought out as named events.
  logic a_sel, b_sel;
  assign a_sel = a_cs & a_en & a_mb_sel;
  assign b_sel = b_cs & b_en & b_mb_sel;

  logic [NCH-1:0]  ch_wclk, ch_rclk, ch_wr, ch_rd;
  logic [MB_W-1:0] ch_wdata [NCH];
  logic [MB_W-1:0] ch_rdata [NCH];
  logic [NCH-1:0]  ch_full, ch_ready, ch_accept, ch_take;

  assign ch_wclk = {clk_b, clk_a};
  assign ch_rclk = {clk_a, clk_b};
  assign ch_wr   = {b_sel & b_wr, a_sel & a_wr};
  assign ch_rd   = {a_sel & ~a_wr, b_sel & ~b_wr};
  assign ch_wdata[0] = a_wdata;
  assign ch_wdata[1] = b_wdata;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mbox_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .wclk(ch_wclk[g]), .rclk(ch_rclk[g]), .rst_n(rst_n), .size(size_e),
      .wr_req(ch_wr[g]), .wr_data(ch_wdata[g]), .rd_req(ch_rd[g]),
      .rd_data(ch_rdata[g]), .full_w(ch_full[g]), .ready_r(ch_ready[g]),
      .wr_accept(ch_accept[g]), .rd_take(ch_take[g]));
  end

  assign b_rdata      = ch_rdata[0];
  assign a_rdata      = ch_rdata[1];
  assign b_mail_ready = ch_ready[0];
  assign a_mail_ready = ch_ready[1];

  // A deselected port performs no mailbox write.
  assert_gated_write_a_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_sel |-> !ch_accept[0]);
  assert_gated_write_b_R8: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_sel |-> !ch_accept[1]);

  // During reset the visible state is empty.
  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R7: assert (a_mail_ready == 1'b0 && b_mail_ready == 1'b0);
    end
  end
endmodule

// File: tb/mailbox_bypass_test.sv
module mailbox_bypass_test;
  logic        clk_a = 0, clk_b = 0, rst_n = 0;
  logic [1:0]  bus_size = 2'b00;
  logic        a_cs = 0, a_en = 0, a_mb_sel = 0, a_wr = 0;
  logic        b_cs = 0, b_en = 0, b_mb_sel = 0, b_wr = 0;
  logic [35:0] a_wdata = '0, b_wdata = '0;
  logic [35:0] a_rdata, b_rdata;
  logic        a_mail_ready, b_mail_ready;

  int checks = 0, fails = 0;

  always #5   clk_a = ~clk_a;   // 100 MHz
  always #6.5 clk_b = ~clk_b;   // unrelated second clock

  mailbox_bypass uut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .bus_size(bus_size),
    .a_cs(a_cs), .a_en(a_en), .a_mb_sel(a_mb_sel), .a_wr(a_wr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_mail_ready(a_mail_ready),
    .b_cs(b_cs), .b_en(b_en), .b_mb_sel(b_mb_sel), .b_wr(b_wr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_mail_ready(b_mail_ready));

  function automatic logic [35:0] keep(input logic [1:0] sz, input logic [35:0] d);
    if (sz == 2'b00) return d;
    if (sz == 2'b01) return {18'd0, d[17:0]};
    return {27'd0, d[8:0]};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_access(input logic wr, input logic [35:0] d,
                          input logic cs, input logic en, input logic sel);
    @(negedge clk_a);
    a_cs = cs; a_en = en; a_mb_sel = sel; a_wr = wr; a_wdata = d;
    @(posedge clk_a); #1;
    a_cs = 0; a_en = 0; a_mb_sel = 0; a_wr = 0;
  endtask

  task automatic b_access(input logic wr, input logic [35:0] d,
                          input logic cs, input logic en, input logic sel);
    @(negedge clk_b);
    b_cs = cs; b_en = en; b_mb_sel = sel; b_wr = wr; b_wdata = d;
    @(posedge clk_b); #1;
    b_cs = 0; b_en = 0; b_mb_sel = 0; b_wr = 0;
  endtask

  task automatic wait_b(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_b);
    #1;
  endtask

  task automatic wait_a(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_a);
    #1;
  endtask

  task automatic t_reset;
    #1;
    check("R7 b_mail_ready", {35'd0, b_mail_ready}, 36'd0);
    check("R7 a_mail_ready", {35'd0, a_mail_ready}, 36'd0);
    check("R7 b_rdata", b_rdata, 36'd0);
    check("R7 a_rdata", a_rdata, 36'd0);
  endtask

  task automatic t_a_to_b(input logic [1:0] sz, input logic [35:0] d);
    bus_size = sz;
    a_access(1, d, 1, 1, 1);
    wait_b(3);
    check("R4 b flag set", {35'd0, b_mail_ready}, 36'd1);
    b_access(0, '0, 1, 1, 1);
    check("R1/R3 b_rdata", b_rdata, keep(sz, d));
    check("R6 b flag cleared", {35'd0, b_mail_ready}, 36'd0);
    wait_a(4);
  endtask

  task automatic t_b_to_a(input logic [1:0] sz, input logic [35:0] d);
    bus_size = sz;
    b_access(1, d, 1, 1, 1);
    wait_a(3);
    check("R4 a flag set", {35'd0, a_mail_ready}, 36'd1);
    a_access(0, '0, 1, 1, 1);
    check("R2/R3 a_rdata", a_rdata, keep(sz, d));
    check("R6 a flag cleared", {35'd0, a_mail_ready}, 36'd0);
    wait_b(4);
  endtask

  task automatic t_no_overwrite;
    bus_size = 2'b00;
    a_access(1, 36'h123456789, 1, 1, 1);
    a_access(1, 36'hFEDCBA987, 1, 1, 1);
    wait_b(3);
    b_access(0, '0, 1, 1, 1);
    check("R5 old word kept", b_rdata, 36'h123456789);
    wait_a(4);
  endtask

  task automatic t_gating;
    bus_size = 2'b00;
    a_access(1, 36'h0AAAAAAAA, 0, 1, 1);
    a_access(1, 36'h0BBBBBBBB, 1, 0, 1);
    a_access(1, 36'h0CCCCCCCC, 1, 1, 0);
    wait_b(4);
    check("R8 b flag stays low", {35'd0, b_mail_ready}, 36'd0);
    b_access(1, 36'h0DDDDDDDD, 1, 1, 0);
    wait_a(4);
    check("R8 a flag stays low", {35'd0, a_mail_ready}, 36'd0);
    // read of empty mailbox leaves flag low
    b_access(0, '0, 1, 1, 1);
    check("R6 empty read flag low", {35'd0, b_mail_ready}, 36'd0);
    // a real write still works afterwards
    a_access(1, 36'h0EEEEEEEE, 1, 1, 1);
    wait_b(3);
    b_access(0, '0, 1, 1, 1);
    check("R8/R1 enabled write lands", b_rdata, 36'h0EEEEEEEE);
    wait_a(4);
  endtask

  task automatic t_collide;
    bus_size = 2'b00;
    a_access(1, 36'h111111111, 1, 1, 1);
    wait_b(3);
    fork
      b_access(0, '0, 1, 1, 1);
      a_access(1, 36'h222222222, 1, 1, 1);
    join
    check("R5 collide read old word", b_rdata, 36'h111111111);
    wait_b(5);
    check("R5 colliding write dropped", {35'd0, b_mail_ready}, 36'd0);
    wait_a(4);
  endtask

  initial begin
    t_reset;
    repeat (3) @(posedge clk_a);
    rst_n = 1;
    wait_b(3);
    t_a_to_b(2'b00, 36'hA5A5A5A5A);
    t_a_to_b(2'b01, 36'hFFFFFFFFF);
    t_a_to_b(2'b10, 36'h9C3C3C3C3);
    t_b_to_a(2'b00, 36'h5A5A5A5A5);
    t_b_to_a(2'b11, 36'hFFFFFFFFF);
    t_b_to_a(2'b01, 36'h8000C0001);
    t_no_overwrite;
    t_gating;
    t_collide;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule